// File: doc/BRIEF.md
# Two-Write-Port RAM Built from XOR-Coded Banks

This block gives two fully independent user ports, A and B, each able to read or write any address in every cycle, using two storage banks that each accept only one write per cycle. Bank 0 belongs to port A and bank 1 to port B. A port writes only its own bank. The value it stores is the write data XOR the word the other bank holds at that address. The logical content of an address is the XOR of the two banks there. That XOR always equals the data of the most recent write to the address, whichever port made it.

Each bank has two synchronous read ports. Read port 0 of both banks serves user port A and read port 1 serves user port B. A read request looks up both banks and returns their XOR one cycle later. A write request uses the same read slot to fetch the other bank's word and commits to its own bank one cycle after that. A write therefore spans two cycles. A read in the commit cycle sees the old content, because bank reads sample before the write at the same edge.

When both ports write the same address in the same cycle, port A wins. Port B's write is dropped, and a collision flag is raised in the following cycle.

Top module: `xor_dual_write_ram`

## Requirements
- R1: Out of reset every address reads as zero on both ports, and the collision flag is low.
- R2: A read request (en=1, we=0) presented in cycle t returns, in cycle t+1 on that port's read data output, the most recent data written to the address.
- R3: Both ports may write in the same cycle to different addresses, and both writes take effect.
- R4: A write requested in cycle t is visible to reads requested in cycle t+2 or later on either port. A read requested in cycle t+1 to the same address returns the value held before the write.
- R5: When both ports write the same address in the same cycle, the address afterwards holds port A's data and port B's data is discarded.
- R6: The collision flag is 1 in cycle t+1 exactly when both ports requested a write to the same address in cycle t, and 0 otherwise.
- R7: A read of an address in the same cycle that the other port requests a write to it returns the old data (read-first).
- R8: Back-to-back writes from one port to one address in adjacent cycles leave the later data in place. A write from the other port two or more cycles later replaces it correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; clears both banks |
| a_en | input | 1 | Port A request valid |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_addr | input | ADDR_W | Port A address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, valid the cycle after a read request |
| b_en | input | 1 | Port B request valid |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_addr | input | ADDR_W | Port B address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data, valid the cycle after a read request |
| collision | output | 1 | High for the cycle after a same-address write clash |

## Verification
The design assumes that writes from the two ports to one address are never requested in adjacent cycles. A later writer would otherwise fetch the other bank's word before the earlier write lands, and the XOR encoding would break. Same-cycle clashes are legal and are resolved in favour of port A. The random stimulus remembers which addresses each port tried to write in the previous cycle. Whenever a port would write an address the other port hit one cycle earlier, the stimulus turns that request into a read. The address range is kept narrow so that clashes, read-first hits and overwrites still occur often.

// File: rtl/xdw_pkg.sv
package xdw_pkg;

    localparam int NUM_PORTS = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    function automatic op_e decode_op(input logic en, input logic we);
        if (!en) return OP_IDLE;
        return we ? OP_WRITE : OP_READ;
    endfunction

    // Index of the bank owned by the opposite user port.
    function automatic int peer_of(input int p);
        return (NUM_PORTS - 1) - p;
    endfunction

endpackage

// File: rtl/xdw_bank.sv
module xdw_bank #(
    parameter int DATA_W   = 16,
    parameter int DEPTH    = 32,
    parameter int RD_PORTS = 2,
    localparam int ADDR_W  = $clog2(DEPTH)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              we,
    input  logic [ADDR_W-1:0]                 waddr,
    input  logic [DATA_W-1:0]                 wdata,
    input  logic [RD_PORTS-1:0]               re,
    input  logic [RD_PORTS-1:0][ADDR_W-1:0]   raddr,
    output logic [RD_PORTS-1:0][DATA_W-1:0]   rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Reads sample the array before a same-edge write: read-first.
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else begin
            for (int r = 0; r < RD_PORTS; r++) begin
                if (re[r]) rdata[r] <= mem[raddr[r]];
            end
        end
    end

endmodule

// File: rtl/xdw_port_stage.sv
module xdw_port_stage
    import xdw_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              kill_in,
    output op_e               op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic              kill_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_IDLE;
            addr_q <= '0;
            data_q <= '0;
            kill_q <= 1'b0;
        end else begin
            op_q   <= op_in;
            addr_q <= addr_in;
            data_q <= data_in;
            kill_q <= kill_in;
        end
    end

endmodule

// File: rtl/xor_dual_write_ram.sv
module xor_dual_write_ram
    import xdw_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int DEPTH   = 32,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              collision
);

    logic [NUM_PORTS-1:0]              en_v;
    logic [NUM_PORTS-1:0]              we_v;
    logic [NUM_PORTS-1:0][ADDR_W-1:0]  addr_v;
    logic [NUM_PORTS-1:0][DATA_W-1:0]  wdata_v;
    logic [NUM_PORTS-1:0][DATA_W-1:0]  rdata_v;
    logic [NUM_PORTS-1:0]              kill_v;
    logic                              clash;

    // rd[bank][port]
    logic [NUM_PORTS-1:0][DATA_W-1:0]  rd [NUM_PORTS];

    op_e               op_q   [NUM_PORTS];
    logic [ADDR_W-1:0] addr_q [NUM_PORTS];
    logic [DATA_W-1:0] data_q [NUM_PORTS];
    logic              kill_q [NUM_PORTS];

    logic [NUM_PORTS-1:0]              bank_we;
    logic [ADDR_W-1:0]                 bank_waddr [NUM_PORTS];
    logic [DATA_W-1:0]                 bank_wdata [NUM_PORTS];

    assign en_v    = {b_en, a_en};
    assign we_v    = {b_we, a_we};
    assign addr_v  = {b_addr, a_addr};
    assign wdata_v = {b_wdata, a_wdata};

    // Same-address double write: port A keeps its write, port B is dropped.
    assign clash  = a_en && a_we && b_en && b_we && (a_addr == b_addr);
    assign kill_v = {clash, 1'b0};

    generate
        for (genvar g = 0; g < NUM_PORTS; g++) begin : g_bank
            xdw_bank #(
                .DATA_W   (DATA_W),
                .DEPTH    (DEPTH),
                .RD_PORTS (NUM_PORTS)
            ) u_bank (
                .clk   (clk),
                .rst   (rst),
                .we    (bank_we[g]),
                .waddr (bank_waddr[g]),
                .wdata (bank_wdata[g]),
                .re    (en_v),
                .raddr (addr_v),
                .rdata (rd[g])
            );
        end

        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            localparam int PEER = peer_of(p);

            xdw_port_stage #(
                .DATA_W (DATA_W),
                .ADDR_W (ADDR_W)
            ) u_stage (
                .clk     (clk),
                .rst     (rst),
                .op_in   (decode_op(en_v[p], we_v[p])),
                .addr_in (addr_v[p]),
                .data_in (wdata_v[p]),
                .kill_in (kill_v[p]),
                .op_q    (op_q[p]),
                .addr_q  (addr_q[p]),
                .data_q  (data_q[p]),
                .kill_q  (kill_q[p])
            );

            // Commit cycle: fold the peer bank's word into the stored value.
            assign bank_we[p]    = (op_q[p] == OP_WRITE) && !kill_q[p];
            assign bank_waddr[p] = addr_q[p];
            assign bank_wdata[p] = data_q[p] ^ rd[PEER][p];

            // Logical content is the XOR of both banks.
            assign rdata_v[p] = rd[0][p] ^ rd[1][p];
        end
    endgenerate

    assign a_rdata = rdata_v[0];
    assign b_rdata = rdata_v[1];

    always_ff @(posedge clk) begin
        if (rst) collision <= 1'b0;
        else     collision <= clash;
    end

endmodule

// File: rtl/xdw_checker.sv
module xdw_checker #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              a_en,
    input logic              a_we,
    input logic [ADDR_W-1:0] a_addr,
    input logic              b_en,
    input logic              b_we,
    input logic [ADDR_W-1:0] b_addr,
    input logic              collision,
    input logic [1:0]        bank_we
);

    logic same_wr;
    assign same_wr = a_en && a_we && b_en && b_we && (a_addr == b_addr);

    // R1: first cycle out of reset is quiet
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!collision && bank_we == 2'b00));

    // R3: an unopposed write request commits to its own bank one cycle later
    a_r3_a_commit: assert property (@(posedge clk) disable iff (rst)
        (a_en && a_we) |=> bank_we[0]);

    a_r3_b_commit: assert property (@(posedge clk) disable iff (rst)
        (b_en && b_we && !same_wr) |=> bank_we[1]);

    // R5: losing write never reaches bank 1
    a_r5_loser_dropped: assert property (@(posedge clk) disable iff (rst)
        same_wr |=> !bank_we[1]);

    // R6: flag follows a clash and only a clash
    a_r6_flag_on_clash: assert property (@(posedge clk) disable iff (rst)
        same_wr |=> collision);

    a_r6_flag_quiet: assert property (@(posedge clk) disable iff (rst)
        !same_wr |=> !collision);

    // R2: a read request never commits to a bank
    a_r2_read_no_commit: assert property (@(posedge clk) disable iff (rst)
        (a_en && !a_we) |=> !bank_we[0]);

endmodule

bind xor_dual_write_ram xdw_checker #(.ADDR_W(ADDR_W)) u_xdw_chk (
    .clk       (clk),
    .rst       (rst),
    .a_en      (a_en),
    .a_we      (a_we),
    .a_addr    (a_addr),
    .b_en      (b_en),
    .b_we      (b_we),
    .b_addr    (b_addr),
    .collision (collision),
    .bank_we   (bank_we)
);

// File: tb/xor_dual_write_ram_test.sv
`timescale 1ns/1ps
module xor_dual_write_ram_test;

    localparam int DW    = 16;
    localparam int DEPTH = 32;
    localparam int AW    = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_en = 0, a_we = 0, b_en = 0, b_we = 0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic [DW-1:0] a_rdata, b_rdata;
    logic collision;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    xor_dual_write_ram #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
        .collision(collision)
    );

    // Reference model state
    logic [DW-1:0] ref_mem [DEPTH];
    bit            old_v [2], last_v [2];
    int            old_a [2], last_a [2];
    logic [DW-1:0] old_d [2], last_d [2];
    bit            li_v [2];
    int            li_a [2];
    bit            pend_rd [2];
    logic [DW-1:0] pend_val [2];
    string         pend_tag [2];
    bit            pend_coll;

    function automatic void check(input string req, input logic [DW-1:0] act,
                                  input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endfunction

    function automatic bit is_clash(input bit ae, input bit aw, input int aa,
                                    input bit be, input bit bw, input int ba);
        return ae && aw && be && bw && (aa == ba);
    endfunction

    task automatic step(input string tag,
                        input bit ae, input bit aw, input int aa, input logic [DW-1:0] ad,
                        input bit be, input bit bw, input int ba, input logic [DW-1:0] bd);
        bit cl;
        @(negedge clk);
        if (pend_rd[0]) check({pend_tag[0], " port A"}, a_rdata, pend_val[0]);
        if (pend_rd[1]) check({pend_tag[1], " port B"}, b_rdata, pend_val[1]);
        check("R6 flag", {{(DW-1){1'b0}}, collision}, {{(DW-1){1'b0}}, pend_coll});
        // retire writes requested two cycles ago
        for (int p = 0; p < 2; p++) if (old_v[p]) ref_mem[old_a[p]] = old_d[p];
        for (int p = 0; p < 2; p++) begin
            old_v[p] = last_v[p]; old_a[p] = last_a[p]; old_d[p] = last_d[p];
        end
        cl = is_clash(ae, aw, aa, be, bw, ba);
        last_v[0] = ae && aw;       last_a[0] = aa; last_d[0] = ad;
        last_v[1] = be && bw && !cl; last_a[1] = ba; last_d[1] = bd;
        li_v[0] = ae && aw; li_a[0] = aa;
        li_v[1] = be && bw; li_a[1] = ba;
        pend_rd[0] = ae && !aw; pend_val[0] = ref_mem[aa % DEPTH]; pend_tag[0] = tag;
        pend_rd[1] = be && !bw; pend_val[1] = ref_mem[ba % DEPTH]; pend_tag[1] = tag;
        pend_coll = cl;
        a_en = ae; a_we = aw; a_addr = aa[AW-1:0]; a_wdata = ad;
        b_en = be; b_we = bw; b_addr = ba[AW-1:0]; b_wdata = bd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step("idle", 0, 0, 0, '0, 0, 0, 0, '0);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        for (int p = 0; p < 2; p++) begin
            old_v[p] = 0; last_v[p] = 0; li_v[p] = 0; pend_rd[p] = 0;
            old_a[p] = 0; last_a[p] = 0; li_a[p] = 0;
            old_d[p] = '0; last_d[p] = '0; pend_val[p] = '0; pend_tag[p] = "";
        end
        pend_coll = 0;
        void'($urandom(32'h5eed_0042));
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: everything reads zero after reset
        check("R1 flag", {{(DW-1){1'b0}}, collision}, '0);
        for (int i = 0; i < 16; i++) step("R1", 1, 0, i, '0, 1, 0, i + 16, '0);
        idle(1);

        // R3: simultaneous writes to different addresses both land
        step("R3", 1, 1, 3, 16'h1111, 1, 1, 5, 16'h2222);
        idle(2);
        step("R3", 1, 0, 5, '0, 1, 0, 3, '0);
        idle(1);

        // R7 / R4: read-first in the request cycle and the commit cycle
        step("R7", 1, 1, 7, 16'hAAAA, 1, 0, 7, '0);
        step("R4", 1, 0, 7, '0, 1, 0, 7, '0);
        step("R4", 1, 0, 7, '0, 1, 0, 7, '0);
        idle(1);

        // R5: same-address clash, port A wins
        step("R5", 1, 1, 9, 16'h1234, 1, 1, 9, 16'h5678);
        idle(2);
        step("R5", 1, 0, 9, '0, 1, 0, 9, '0);
        idle(1);

        // R8: back-to-back writes on one port, then the other port takes over
        step("R8", 1, 1, 10, 16'h0001, 0, 0, 0, '0);
        step("R8", 1, 1, 10, 16'h0002, 0, 0, 0, '0);
        idle(2);
        step("R8", 1, 0, 10, '0, 1, 0, 10, '0);
        step("R8", 0, 0, 0, '0, 1, 1, 10, 16'h3333);
        idle(2);
        step("R8", 1, 0, 10, '0, 1, 0, 10, '0);
        step("R8", 1, 1, 3, 16'h4444, 0, 0, 0, '0);
        idle(2);
        step("R8", 1, 0, 3, '0, 1, 0, 3, '0);

        // R2: constrained random traffic over a narrow address window
        for (int n = 0; n < 4000; n++) begin
            bit ae, aw, be, bw;
            int aa, ba;
            logic [DW-1:0] ad, bd;
            ae = ($urandom % 8) != 0; aw = $urandom % 2;
            be = ($urandom % 8) != 0; bw = $urandom % 2;
            aa = $urandom % 8; ba = $urandom % 8;
            ad = DW'($urandom); bd = DW'($urandom);
            // keep cross-port writes to one address at least two cycles apart
            if (aw && li_v[1] && li_a[1] == aa) aw = 0;
            if (bw && li_v[0] && li_a[0] == ba) bw = 0;
            step("R2", ae, aw, aa, ad, be, bw, ba, bd);
        end
        idle(2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule